// File: doc/BRIEF.md
# Masked Vector Compare and Select Unit

The unit runs one elementwise vector command at a time under a per-element
mask. Test commands compare the elements of two operand vectors and write the
result into an internal mask, one bit per element. Compute commands (copy A,
copy B, add, multiply) stream their results out through a vector register write
port. Each beat carries the element index, so the register file leaves elements
that are not written unchanged. A mask complement command inverts the mask.
This turns two masked copies, of A and then of B, into an elementwise select.

The unit takes a vector length with every command. Only elements below that
length are processed, and mask bits at or above it read as zero. The
`DENSITY` parameter picks the execution style. When it is 0, every element
below the length is issued in order and the write enable follows the mask bit.
When it is 1, the unit scans the mask and issues only the set elements, so a
command takes as many cycles as there are set bits.

The command port and the write port use valid/ready. A command is taken when
`cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high only while the
unit is idle. A write beat completes when `wr_valid` and `wr_ready` are both
high. While `wr_ready` is low, the beat on the port holds and the unit stalls.
Operands come through a combinational read port: the unit drives `rd_idx` and
expects `a_elem` and `b_elem` for that element in the same cycle.

Top module: `mvsel_unit`

## Requirements
- R1: After reset `cmd_ready` is 1 and `wr_valid` is 0. `cmd_ready` is 1 exactly when the unit is idle, and no write beat is offered while idle. The `cmd_op` codes are 0 zero-test, 1 not-equal test, 2 greater-or-equal test, 3 mask complement, 4 copy A, 5 copy B, 6 add, 7 multiply.
- R2: Zero-test (code 0) sets mask bit i to (A[i] == 0) for every i below the length and clears every bit at or above it. It keeps the unit busy for exactly length cycles.
- R3: Code 1 sets mask bit i to (A[i] != B[i]). Code 2 sets it to (A[i] >= B[i]), compared unsigned. Both use the same length rules and timing as R2.
- R4: Mask complement (code 3) inverts every mask bit below the length and clears the rest. It completes in the acceptance cycle, so `cmd_ready` never drops.
- R5: Beat data is A[i] for code 4, B[i] for code 5, (A[i]+B[i]) mod 2^EW for code 6, and the low EW bits of A[i]*B[i] for code 7, with the operands taken as unsigned.
- R6: With DENSITY=0, a compute command emits exactly one beat per element 0..length-1, in ascending index order. Each beat's `wr_en` equals that element's mask bit.
- R7: With DENSITY=1, a compute command emits beats only for elements below the length whose mask bit is 1, in ascending index order, each with `wr_en` = 1.
- R8: With `wr_ready` held at 1, a compute command keeps `cmd_ready` low for exactly length cycles (DENSITY=0) or popcount(mask below length) cycles (DENSITY=1). A count of zero leaves `cmd_ready` high throughout.
- R9: While `wr_valid` is 1 and `wr_ready` is 0, the next cycle still offers the same `wr_idx`, `wr_en` and `wr_data`. No beat is lost or repeated under back-pressure.
- R10: A `cmd_vlen` above NELEM acts as NELEM.
- R11: Test and complement commands emit no write beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Unit idle, command accepted this cycle if valid |
| cmd_op | input | 3 | Command code (see R1) |
| cmd_vlen | input | $clog2(NELEM+1) | Vector length for this command |
| rd_idx | output | $clog2(NELEM) | Element index on the operand read port |
| a_elem | input | EW | Operand A element at `rd_idx` |
| b_elem | input | EW | Operand B element at `rd_idx` |
| wr_valid | output | 1 | Write beat offered |
| wr_ready | input | 1 | Register file accepts the beat |
| wr_idx | output | $clog2(NELEM) | Destination element index |
| wr_data | output | EW | Result element |
| wr_en | output | 1 | Element write enable (mask bit) |

## Verification
The bench drives both execution styles side by side and targets the cases where they differ. It checks the beat count and the busy time against the mask population, so a density-time unit that still walked every element would show the extra cycles. An all-zero mask and a zero length must finish without a beat. A unit that spent even one cycle there would drop `cmd_ready`. The bench runs lengths above the register capacity, and stale mask bits beyond a shorter length, to catch missing clamping. A unit that did not clear those bits would write elements it must skip. A select built from test, copy, complement and copy, together with random `wr_ready` stalls, exposes lost or doubled beats and wrong complement bounds.

// File: rtl/mvsel_pkg.sv
package mvsel_pkg;
  typedef enum logic [2:0] {
    OP_TEQZ  = 3'd0,
    OP_TNE   = 3'd1,
    OP_TGE   = 3'd2,
    OP_MNOT  = 3'd3,
    OP_PASSA = 3'd4,
    OP_PASSB = 3'd5,
    OP_ADD   = 3'd6,
    OP_MUL   = 3'd7
  } vop_e;

  function automatic logic op_is_test(vop_e op);
    return (op == OP_TEQZ) || (op == OP_TNE) || (op == OP_TGE);
  endfunction

  function automatic logic op_is_comp(vop_e op);
    return op[2];
  endfunction
endpackage

// File: rtl/mvsel_alu.sv
module mvsel_alu
  import mvsel_pkg::*;
#(
  parameter int EW = 16
) (
  input  vop_e          op,
  input  logic [EW-1:0] a,
  input  logic [EW-1:0] b,
  output logic [EW-1:0] res,
  output logic          hit
);
  logic [2*EW-1:0] prod;

  assign prod = {{EW{1'b0}}, a} * {{EW{1'b0}}, b};

  always_comb begin
    hit = 1'b0;
    res = '0;
    unique case (op)
      OP_TEQZ:  hit = (a == '0);
      OP_TNE:   hit = (a != b);
      OP_TGE:   hit = (a >= b);
      OP_PASSA: res = a;
      OP_PASSB: res = b;
      OP_ADD:   res = a + b;
      OP_MUL:   res = prod[EW-1:0];
      default:  res = '0;
    endcase
  end
endmodule

// File: rtl/mvsel_lead_one.sv
module mvsel_lead_one #(
  parameter int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  onehot,
  output logic          any
);
  // Lowest set bit wins: scan from the top so the last hit is the lowest.
  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        idx = IW'(i);
        any = 1'b1;
      end
    end
  end

  assign onehot = vec & (~vec + N'(1));
endmodule

// File: rtl/mvsel_limit.sv
module mvsel_limit #(
  parameter int N  = 8,
  localparam int LW = $clog2(N + 1)
) (
  input  logic [LW-1:0] vlen,
  output logic [N-1:0]  lim
);
  for (genvar g = 0; g < N; g++) begin : g_lim
    assign lim[g] = (32'(vlen) > g);
  end
endmodule

// File: rtl/mvsel_unit.sv
module mvsel_unit
  import mvsel_pkg::*;
#(
  parameter int NELEM   = 8,
  parameter int EW      = 16,
  parameter bit DENSITY = 1'b0,
  localparam int IW = (NELEM > 1) ? $clog2(NELEM) : 1,
  localparam int LW = $clog2(NELEM + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [2:0]    cmd_op,
  input  logic [LW-1:0] cmd_vlen,
  output logic [IW-1:0] rd_idx,
  input  logic [EW-1:0] a_elem,
  input  logic [EW-1:0] b_elem,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [IW-1:0] wr_idx,
  output logic [EW-1:0] wr_data,
  output logic          wr_en
);
  vop_e             op_q, cmd_op_e;
  logic             busy;
  logic [LW-1:0]    vlen_q, vlen_c;
  logic [IW-1:0]    cnt, cur_idx, lead_idx;
  logic [NELEM-1:0] vmask, pend, lim, lead_oh, live;
  logic             lead_any, accept, step, cnt_last, seq_last, hit;
  logic             q_test, q_comp;

  assign cmd_op_e  = vop_e'(cmd_op);
  assign vlen_c    = (32'(cmd_vlen) > NELEM) ? LW'(NELEM) : cmd_vlen;
  assign cmd_ready = ~busy;
  assign accept    = cmd_valid & cmd_ready;
  assign q_test    = op_is_test(op_q);
  assign q_comp    = op_is_comp(op_q);
  assign live      = vmask & lim;
  assign cnt_last  = ((LW'(cnt) + LW'(1)) == vlen_q);

  mvsel_limit #(.N(NELEM)) u_limit (
    .vlen (vlen_c),
    .lim  (lim)
  );

  mvsel_lead_one #(.N(NELEM)) u_lead (
    .vec    (pend),
    .idx    (lead_idx),
    .onehot (lead_oh),
    .any    (lead_any)
  );

  mvsel_alu #(.EW(EW)) u_alu (
    .op  (op_q),
    .a   (a_elem),
    .b   (b_elem),
    .res (wr_data),
    .hit (hit)
  );

  if (DENSITY) begin : g_dense
    logic rest_empty;
    assign rest_empty = ((pend & ~lead_oh) == '0);
    assign cur_idx    = q_test ? cnt : lead_idx;
    assign seq_last   = q_test ? cnt_last : rest_empty;
    assign wr_en      = lead_any;
  end else begin : g_simple
    assign cur_idx  = cnt;
    assign seq_last = cnt_last;
    assign wr_en    = vmask[cnt];
  end

  assign rd_idx   = cur_idx;
  assign wr_idx   = cur_idx;
  assign wr_valid = busy & q_comp;
  assign step     = busy & (q_test | wr_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      op_q   <= OP_TEQZ;
      vlen_q <= '0;
      cnt    <= '0;
      vmask  <= '0;
      pend   <= '0;
    end else if (accept) begin
      op_q   <= cmd_op_e;
      vlen_q <= vlen_c;
      cnt    <= '0;
      pend   <= live;
      if (cmd_op_e == OP_MNOT) begin
        vmask <= ~vmask & lim;
        busy  <= 1'b0;
      end else if (op_is_test(cmd_op_e)) begin
        vmask <= live;
        busy  <= (vlen_c != '0);
      end else begin
        busy  <= DENSITY ? (live != '0) : (vlen_c != '0);
      end
    end else if (step) begin
      cnt <= cnt + IW'(1);
      if (q_test) vmask[cnt] <= hit;
      if (DENSITY && q_comp) pend <= pend & ~lead_oh;
      if (seq_last) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/mvsel_unit_chk.sv
module mvsel_unit_chk #(
  parameter int NELEM   = 8,
  parameter int EW      = 16,
  parameter bit DENSITY = 1'b0,
  localparam int IW = (NELEM > 1) ? $clog2(NELEM) : 1,
  localparam int LW = $clog2(NELEM + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_ready,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [IW-1:0] wr_idx,
  input logic [EW-1:0] wr_data,
  input logic          wr_en,
  input logic [LW-1:0] vlen_q
);
  a_r9_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_idx) && $stable(wr_en) && $stable(wr_data));

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !wr_valid);

  a_r10_idx_in_len: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (32'(wr_idx) < 32'(vlen_q)));

  if (DENSITY) begin : g_dense_chk
    a_r7_en_set: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> wr_en);
    a_r7_ascending: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && wr_ready |=> !wr_valid || (wr_idx > $past(wr_idx)));
  end else begin : g_simple_chk
    a_r6_next_index: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && wr_ready |=> !wr_valid || (wr_idx == IW'($past(wr_idx) + 1'b1)));
  end
endmodule

bind mvsel_unit mvsel_unit_chk #(.NELEM(NELEM), .EW(EW), .DENSITY(DENSITY)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_ready (cmd_ready),
  .wr_valid  (wr_valid),
  .wr_ready  (wr_ready),
  .wr_idx    (wr_idx),
  .wr_data   (wr_data),
  .wr_en     (wr_en),
  .vlen_q    (vlen_q)
);

// File: tb/mvsel_unit_tb_top.sv
module mvsel_unit_tb_top;
  localparam int NE = 8;
  localparam int EW = 16;
  localparam int IW = $clog2(NE);
  localparam int LW = $clog2(NE + 1);
  localparam int BW = EW + IW + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          cmd_valid = 1'b0;
  logic [2:0]    cmd_op = '0;
  logic [LW-1:0] cmd_vlen = '0;
  logic [EW-1:0] va [NE];
  logic [EW-1:0] vb [NE];

  logic s_ready, s_wv, s_en, d_ready, d_wv, d_en;
  logic s_wr_rdy = 1'b1, d_wr_rdy = 1'b1;
  logic [IW-1:0] s_rd, s_wi, d_rd, d_wi;
  logic [EW-1:0] s_a, s_b, s_wd, d_a, d_b, d_wd;

  assign s_a = va[s_rd];
  assign s_b = vb[s_rd];
  assign d_a = va[d_rd];
  assign d_b = vb[d_rd];

  mvsel_unit #(.NELEM(NE), .EW(EW), .DENSITY(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(s_ready),
    .cmd_op(cmd_op), .cmd_vlen(cmd_vlen), .rd_idx(s_rd), .a_elem(s_a), .b_elem(s_b),
    .wr_valid(s_wv), .wr_ready(s_wr_rdy), .wr_idx(s_wi), .wr_data(s_wd), .wr_en(s_en));

  mvsel_unit #(.NELEM(NE), .EW(EW), .DENSITY(1'b1)) dut_dt (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(d_ready),
    .cmd_op(cmd_op), .cmd_vlen(cmd_vlen), .rd_idx(d_rd), .a_elem(d_a), .b_elem(d_b),
    .wr_valid(d_wv), .wr_ready(d_wr_rdy), .wr_idx(d_wi), .wr_data(d_wd), .wr_en(d_en));

  int nchk = 0;
  int nfail = 0;
  bit bp_on = 1'b0;
  logic [15:0] lf = 16'hACE1;
  logic [NE-1:0] mmask = '0;
  logic [BW-1:0] q_s[$];
  logic [BW-1:0] q_d[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [EW-1:0] ref_res(int op, logic [EW-1:0] a, logic [EW-1:0] b);
    logic [EW-1:0] r;
    case (op)
      4: r = a;
      5: r = b;
      6: r = a + b;
      default: r = a * b;
    endcase
    return r;
  endfunction

  function automatic bit ref_hit(int op, logic [EW-1:0] a, logic [EW-1:0] b);
    case (op)
      0: return a == '0;
      1: return a != b;
      default: return a >= b;
    endcase
  endfunction

  // Per-clock compare of the write ports against the expected beat queues
  always @(negedge clk) begin
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    s_wr_rdy = bp_on ? lf[0] : 1'b1;
    d_wr_rdy = bp_on ? lf[3] : 1'b1;
    #1;
    if (rst_n && s_wv && s_wr_rdy) begin
      if (q_s.size() == 0) chk(0, "R11", "simple: unexpected beat", {s_en, s_wi, s_wd}, 0);
      else begin
        logic [BW-1:0] e;
        e = q_s.pop_front();
        chk({s_en, s_wi, s_wd} == e, "R6 R5", "simple beat {en,idx,data}", {s_en, s_wi, s_wd}, e);
      end
    end
    if (rst_n && d_wv && d_wr_rdy) begin
      if (q_d.size() == 0) chk(0, "R7", "density: unexpected beat", {d_en, d_wi, d_wd}, 0);
      else begin
        logic [BW-1:0] e;
        e = q_d.pop_front();
        chk({d_en, d_wi, d_wd} == e, "R7 R5", "density beat {en,idx,data}", {d_en, d_wi, d_wd}, e);
      end
    end
  end

  task automatic run_cmd(input int op, input int vl, input bit bp);
    int vc, es, ed, cs, cd, pc;
    logic [NE-1:0] nm;
    vc = (vl > NE) ? NE : vl;
    pc = 0;
    nm = mmask;
    for (int i = 0; i < NE; i++) begin
      if (op >= 4 && i < vc) begin
        logic [EW-1:0] r;
        r = ref_res(op, va[i], vb[i]);
        q_s.push_back({mmask[i], IW'(i), r});
        if (mmask[i]) begin
          q_d.push_back({1'b1, IW'(i), r});
          pc++;
        end
      end
      if (op < 3) nm[i] = (i < vc) ? ref_hit(op, va[i], vb[i]) : 1'b0;
      if (op == 3) nm[i] = (i < vc) ? ~mmask[i] : 1'b0;
    end
    es = (op == 3) ? 0 : vc;
    ed = (op == 3) ? 0 : (op < 3) ? vc : pc;
    bp_on = bp;
    @(negedge clk);
    cmd_op = 3'(op);
    cmd_vlen = LW'(vl);
    cmd_valid = 1'b1;
    @(posedge clk);
    #1 cmd_valid = 1'b0;
    cs = 0;
    cd = 0;
    @(negedge clk);
    #2;
    while (!(s_ready && d_ready)) begin
      if (!s_ready) cs++;
      if (!d_ready) cd++;
      @(negedge clk);
      #2;
    end
    bp_on = 1'b0;
    chk(q_s.size() == 0, "R6", "simple beats missing", q_s.size(), 0);
    chk(q_d.size() == 0, "R7", "density beats missing", q_d.size(), 0);
    q_s.delete();
    q_d.delete();
    if (!bp || op < 4) begin
      chk(cs == es, (op < 3) ? "R2" : (op == 3) ? "R4" : "R8", "simple busy cycles", cs, es);
      chk(cd == ed, (op < 3) ? "R3" : (op == 3) ? "R4" : "R8", "density busy cycles", cd, ed);
    end
    mmask = nm;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    for (int i = 0; i < NE; i++) begin
      va[i] = (i % 3 == 0) ? '0 : EW'(i * 1000 + 7);
      vb[i] = EW'(i * 300);
    end
    repeat (3) @(posedge clk);
    #1;
    chk(s_ready && d_ready, "R1", "ready after reset", {s_ready, d_ready}, 2'b11);
    chk(!s_wv && !d_wv, "R1", "no beat in reset", {s_wv, d_wv}, 0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    // R2 zero-test then masked copy, both styles
    run_cmd(0, 8, 0);
    run_cmd(4, 8, 0);
    // R3 not-equal with shorter length, add under back-pressure (R9)
    run_cmd(1, 6, 0);
    run_cmd(6, 8, 1);
    run_cmd(7, 8, 0);
    // R4 select: A>=B, copy A, complement, copy B
    run_cmd(2, 8, 0);
    run_cmd(4, 8, 0);
    run_cmd(3, 8, 0);
    run_cmd(5, 8, 0);
    // R4 complement over a short length clears bits beyond it
    run_cmd(3, 3, 0);
    run_cmd(4, 8, 0);
    // R10 length above capacity
    run_cmd(2, 15, 0);
    run_cmd(6, 15, 1);
    // R8 zero length and all-zero mask finish at once
    run_cmd(4, 0, 0);
    for (int i = 0; i < NE; i++) vb[i] = va[i];
    run_cmd(1, 8, 0);
    run_cmd(7, 8, 0);
    run_cmd(5, 8, 1);
    // R11 test and complement commands leave the write port quiet (monitor flags beats)
    run_cmd(0, 0, 0);
    run_cmd(3, 0, 0);

    for (int it = 0; it < 40; it++) begin
      for (int i = 0; i < NE; i++) begin
        va[i] = ($urandom_range(0, 3) == 0) ? '0 : EW'($urandom_range(0, 5));
        vb[i] = EW'($urandom);
        if ($urandom_range(0, 2) == 0) vb[i] = va[i];
      end
      run_cmd($urandom_range(0, 3), $urandom_range(0, 10), 0);
      run_cmd($urandom_range(4, 7), $urandom_range(0, 10), it[0]);
    end

    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule